// File: doc/BRIEF.md
# Masked Sync-Word Correlator

This block watches a serial bit stream for a synchronisation word. Received bits enter a window register of `WIN` bits, one bit per enabled clock. The bit that drops out of the far end is presented on a serial output, so a second unit can extend the window. Every clock, each window position is compared with the matching position of a reference word. A position whose mask bit is set is counted as a match whatever the data. A binary adder tree totals the matches. The block also counts the masked positions.

Two tolerances are applied to these totals. The true-word test fires when the number of mismatches is no more than the true tolerance. The inverted-word test fires when the number of genuine matches is no more than the inverted tolerance. Either test raises `detect`, and a small state machine then holds an interrupt until software acknowledges it.

For a window of twice the width, two units are chained. The slave's serial input is fed from the master's serial output. The master adds the slave's match and mask totals to its own before it decides. The reference, mask, tolerances and mode are plain parallel inputs.

The interrupt machine has two states. `IRQ_IDLE` moves to `IRQ_PEND` on the SET transition, which is taken when either registered detection is high. `IRQ_PEND` returns to `IRQ_IDLE` on the CLEAR transition, which is taken when `irq_ack` is high and no detection is registered in that cycle. Otherwise each state holds.

Top module: `sync_corr`

## Requirements
- R1: When `shift_en` is 1 at a clock edge, the window shifts by one position. `ser_in` enters bit 0 and the previous bit `WIN-2` moves to bit `WIN-1`. `ser_out` always shows bit `WIN-1`, so a bit appears on `ser_out` after `WIN` enabled shifts. When `shift_en` is 0, the window holds.
- R2: `casc_cnt_out` equals the number of positions i where window bit i equals `ref_word[i]` or `mask_word[i]` is 1. `casc_msk_out` equals the number of 1s in `mask_word`. Both are combinational from the current window.
- R3: A position whose mask bit is 1 counts as a match for every window and reference value. With the mask all 1s, `casc_cnt_out` equals `WIN`.
- R4: `det_true` is registered. After an edge it is 1 exactly when, for the window and inputs present before that edge, the total plus `tol_true` is at least N. N is `WIN`, or `2*WIN` in master mode.
- R5: `det_inv` is registered with the same timing as R4. It is 1 exactly when the total is at most `tol_inv` plus the masked total.
- R6: When `casc_master` is 1, the total is the local count plus `casc_cnt_in` and the masked total is the local mask count plus `casc_msk_in`. When `casc_master` is 0, both cascade inputs have no effect on `det_true` or `det_inv`. The cascade inputs must not exceed `WIN`.
- R7: `irq` is set one edge after `det_true` or `det_inv` is registered high. It stays set until an edge where `irq_ack` is 1 and neither detection is high. A detection wins over a simultaneous acknowledge.
- R8: While `rst_n` is 0, the window is cleared and `det_true`, `det_inv`, `detect` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift the window by one bit |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Oldest window bit, for chaining |
| ref_word | input | WIN | Reference sync word |
| mask_word | input | WIN | 1 = position forced to match |
| tol_true | input | CW | Allowed mismatches, true word |
| tol_inv | input | CW | Allowed genuine matches, inverted word |
| casc_master | input | 1 | 1 = add slave totals |
| casc_cnt_in | input | CW | Slave match total |
| casc_msk_in | input | CW | Slave masked total |
| casc_cnt_out | output | CW | Local match total |
| casc_msk_out | output | CW | Local masked total |
| irq_ack | input | 1 | Clears a pending interrupt |
| det_true | output | 1 | True word detected |
| det_inv | output | 1 | Inverted word detected |
| detect | output | 1 | Either detection |
| irq | output | 1 | Sticky interrupt |

## Verification
The bench builds the block with `WIN` = 128, which gives a 9-bit count path. At this width the window can be filled exactly with the reference, with its inverse, or with a chosen number of flipped bits, so each tolerance can be tested on both sides of its boundary. Master mode with large slave totals pushes the sum up to the 256-bit limit. Free-running random traffic mixes masking, cascading and acknowledges against a behavioural model.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/corr_window.sv
module corr_window #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [N-1:0] win_q,
    output logic         ser_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= {win_q[N-2:0], ser_in};
        end
    end

    assign ser_out = win_q[N-1];

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> win_q[0] == $past(ser_in));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(win_q));
endmodule

// File: rtl/corr_popcount.sv
module corr_popcount #(
    parameter  int N  = 128,
    localparam int LV = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic [LV:0]  total
);
    genvar l, i;
    for (l = 0; l <= LV; l++) begin : g_lvl
        logic [l:0] s [N>>l];
        if (l == 0) begin : g_leaf
            for (i = 0; i < N; i++) begin : g_b
                assign s[i] = bits[i];
            end
        end else begin : g_add
            for (i = 0; i < (N >> l); i++) begin : g_n
                assign s[i] = {1'b0, g_lvl[l-1].s[2*i]} + {1'b0, g_lvl[l-1].s[2*i+1]};
            end
        end
    end

    assign total = g_lvl[LV].s[0];
endmodule

// File: rtl/corr_decide.sv
module corr_decide #(
    parameter int N  = 128,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_loc,
    input  logic [CW-1:0] msk_loc,
    input  logic          master,
    input  logic [CW-1:0] cnt_ext,
    input  logic [CW-1:0] msk_ext,
    input  logic [CW-1:0] tol_true,
    input  logic [CW-1:0] tol_inv,
    output logic          det_true,
    output logic          det_inv
);
    logic [CW-1:0] tot, msk_tot, nbits;
    logic          hit_true, hit_inv;

    always_comb begin
        tot     = master ? cnt_loc + cnt_ext : cnt_loc;
        msk_tot = master ? msk_loc + msk_ext : msk_loc;
        nbits   = master ? CW'(2 * N) : CW'(N);
        hit_true = ({1'b0, tot} + {1'b0, tol_true}) >= {1'b0, nbits};
        hit_inv  = {1'b0, tot} <= ({1'b0, tol_inv} + {1'b0, msk_tot});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_true <= 1'b0;
            det_inv  <= 1'b0;
        end else begin
            det_true <= hit_true;
            det_inv  <= hit_inv;
        end
    end

    assert_exact_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && cnt_loc == CW'(N)) |=> det_true);
endmodule

// File: rtl/corr_irq_fsm.sv
module corr_irq_fsm
    import sync_corr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (hit)         state_d = IRQ_PEND;
            IRQ_PEND: if (ack && !hit) state_d = IRQ_IDLE;
            default:                   state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !irq);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

// File: rtl/sync_corr.sv
module sync_corr #(
    parameter  int WIN = 128,
    localparam int CW  = $clog2(2 * WIN + 1),
    localparam int PW  = $clog2(WIN) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           ser_in,
    output logic           ser_out,
    input  logic [WIN-1:0] ref_word,
    input  logic [WIN-1:0] mask_word,
    input  logic [CW-1:0]  tol_true,
    input  logic [CW-1:0]  tol_inv,
    input  logic           casc_master,
    input  logic [CW-1:0]  casc_cnt_in,
    input  logic [CW-1:0]  casc_msk_in,
    output logic [CW-1:0]  casc_cnt_out,
    output logic [CW-1:0]  casc_msk_out,
    input  logic           irq_ack,
    output logic           det_true,
    output logic           det_inv,
    output logic           detect,
    output logic           irq
);
    logic [WIN-1:0] win_q;
    logic [WIN-1:0] agree;
    logic [PW-1:0]  cnt_raw, msk_raw;

    corr_window #(.N(WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
        .win_q(win_q), .ser_out(ser_out)
    );

    assign agree = ~(win_q ^ ref_word) | mask_word;

    corr_popcount #(.N(WIN)) u_cnt (.bits(agree),     .total(cnt_raw));
    corr_popcount #(.N(WIN)) u_msk (.bits(mask_word), .total(msk_raw));

    assign casc_cnt_out = CW'(cnt_raw);
    assign casc_msk_out = CW'(msk_raw);

    corr_decide #(.N(WIN), .CW(CW)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .cnt_loc(casc_cnt_out), .msk_loc(casc_msk_out),
        .master(casc_master), .cnt_ext(casc_cnt_in), .msk_ext(casc_msk_in),
        .tol_true(tol_true), .tol_inv(tol_inv),
        .det_true(det_true), .det_inv(det_inv)
    );

    assign detect = det_true | det_inv;

    corr_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n), .hit(detect), .ack(irq_ack), .irq(irq)
    );

    assert_mask_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        casc_cnt_out >= casc_msk_out);
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        casc_cnt_out <= CW'(WIN));
endmodule

// File: tb/sync_corr_tb_top.sv
`timescale 1ns/1ps
module sync_corr_tb_top;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0, ser_in = 1'b0;
    logic         ser_out;
    logic [W-1:0] ref_word = '0, mask_word = '0;
    logic [8:0]   tol_true = '0, tol_inv = '0;
    logic         casc_master = 1'b0;
    logic [8:0]   casc_cnt_in = '0, casc_msk_in = '0;
    logic [8:0]   casc_cnt_out, casc_msk_out;
    logic         irq_ack = 1'b0;
    logic         det_true, det_inv, detect, irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sync_corr #(.WIN(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
        .ref_word(ref_word), .mask_word(mask_word), .tol_true(tol_true), .tol_inv(tol_inv),
        .casc_master(casc_master), .casc_cnt_in(casc_cnt_in), .casc_msk_in(casc_msk_in),
        .casc_cnt_out(casc_cnt_out), .casc_msk_out(casc_msk_out), .irq_ack(irq_ack),
        .det_true(det_true), .det_inv(det_inv), .detect(detect), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [W-1:0] m_win = '0;
    bit e_dt = 0, e_di = 0, e_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = '0; e_dt = 0; e_di = 0; e_irq = 0;
        end else begin
            int lc, lm, tt, mt, nb;
            lc = $countones(~(m_win ^ ref_word) | mask_word);
            lm = $countones(mask_word);
            tt = casc_master ? lc + int'(casc_cnt_in) : lc;
            mt = casc_master ? lm + int'(casc_msk_in) : lm;
            nb = casc_master ? 2 * W : W;
            e_irq = (e_dt || e_di) || (e_irq && !irq_ack);
            e_dt  = (tt + int'(tol_true)) >= nb;
            e_di  = tt <= (int'(tol_inv) + mt);
            if (shift_en) m_win = {m_win[W-2:0], ser_in};
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            int lc;
            lc = $countones(~(m_win ^ ref_word) | mask_word);
            check(ser_out == m_win[W-1], "R1 ser_out", ser_out, m_win[W-1]);
            check(int'(casc_cnt_out) == lc, "R2 match count", casc_cnt_out, lc);
            check(int'(casc_msk_out) == $countones(mask_word), "R2 mask count",
                  casc_msk_out, $countones(mask_word));
            check(det_true == e_dt, casc_master ? "R6 det_true" : "R4 det_true", det_true, e_dt);
            check(det_inv == e_di, casc_master ? "R6 det_inv" : "R5 det_inv", det_inv, e_di);
            check(irq == e_irq, "R7 irq", irq, e_irq);
        end
    end

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            shift_en = 1'b1;
            ser_in   = w[i];
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    localparam logic [W-1:0] REF = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;

    initial begin
        ref_word = REF;
        tol_true = 9'd4;
        tol_inv  = 9'd4;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(ser_out == 1'b0 && det_true == 1'b0 && det_inv == 1'b0, "R8 outputs", det_true, 0);
        check(detect == 1'b0 && irq == 1'b0, "R8 irq", irq, 0);
        rst_n = 1'b1;

        // random traffic, standalone
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            shift_en = 1'b1;
            ser_in   = 1'($urandom);
        end
        @(negedge clk); shift_en = 1'b0;
        irq_ack = 1'b1; settle(); @(negedge clk); irq_ack = 1'b0;

        // R4: exact true word
        shift_word(REF);
        settle();
        check(det_true == 1'b1, "R4 exact word", det_true, 1);
        check(ser_out == REF[W-1], "R1 oldest bit out", ser_out, REF[W-1]);
        // R1: window holds without shift_en
        repeat (5) @(negedge clk);
        check(int'(casc_cnt_out) == W, "R1 hold", casc_cnt_out, W);
        // R7: sticky, then ack while detection holds keeps irq
        check(irq == 1'b1, "R7 set", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        settle();
        check(irq == 1'b1, "R7 set wins", irq, 1);
        @(negedge clk); irq_ack = 1'b0;

        // R4: boundary with three flipped bits
        shift_word(REF ^ 128'h8000_0000_0001_0000_0000_0000_0000_0040);
        @(negedge clk); tol_true = 9'd3; settle();
        check(det_true == 1'b1, "R4 tol equal", det_true, 1);
        @(negedge clk); tol_true = 9'd2; settle();
        check(det_true == 1'b0, "R4 tol below", det_true, 0);
        @(negedge clk); irq_ack = 1'b1; settle(); settle();
        check(irq == 1'b0, "R7 clear", irq, 0);
        @(negedge clk); irq_ack = 1'b0;

        // R5: inverted word with two agreeing bits
        shift_word(~REF ^ 128'h0000_0100_0000_0000_0000_0000_0000_0002);
        @(negedge clk); tol_inv = 9'd1; settle();
        check(det_inv == 1'b0, "R5 tol below", det_inv, 0);
        @(negedge clk); tol_inv = 9'd2; settle();
        check(det_inv == 1'b1, "R5 tol equal", det_inv, 1);

        // R3: mask forces matches
        @(negedge clk); mask_word = {W{1'b1}}; settle();
        check(int'(casc_cnt_out) == W, "R3 all masked", casc_cnt_out, W);
        @(negedge clk); mask_word = {{64{1'b0}}, {64{1'b1}}};
        shift_word({REF[W-1:64], ~REF[63:0]});
        @(negedge clk); tol_true = 9'd0; tol_inv = 9'd0; settle();
        check(det_true == 1'b1, "R3 masked half", det_true, 1);

        // R6: cascade inputs ignored when not master
        @(negedge clk); mask_word = '0; casc_cnt_in = 9'd0; casc_msk_in = 9'd128; tol_inv = 9'd0;
        shift_word(~REF);
        settle();
        check(det_inv == 1'b1, "R6 slave ignores", det_inv, 1);
        // R6: master sums
        shift_word(REF);
        @(negedge clk); casc_master = 1'b1; casc_cnt_in = 9'd100; casc_msk_in = 9'd0; tol_true = 9'd28;
        settle();
        check(det_true == 1'b1, "R6 master at limit", det_true, 1);
        @(negedge clk); tol_true = 9'd27; settle();
        check(det_true == 1'b0, "R6 master below", det_true, 0);
        @(negedge clk); casc_cnt_in = 9'd128; tol_true = 9'd0; settle();
        check(det_true == 1'b1, "R6 full 256", det_true, 1);

        // random mixed traffic
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            shift_en    = 1'($urandom);
            ser_in      = 1'($urandom);
            irq_ack     = ($urandom % 4) == 0;
            if (i % 40 == 0) begin
                casc_master = 1'($urandom);
                mask_word   = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
                tol_true    = 9'($urandom % 80);
                tol_inv     = 9'($urandom % 80);
                casc_cnt_in = 9'($urandom % 129);
                casc_msk_in = 9'($urandom % 129);
            end
        end
        @(negedge clk); shift_en = 1'b0;
        settle();
        finish_run();
    end
endmodule